// File: doc/BRIEF.md
# Double-Buffered DMA Block Sequencer

This block is the address and block-length engine of one DMA channel. It keeps a current length and a current address. It also keeps a shadow pair, a pending length and a pending start address, so software can prepare the next block while the current one is still running. Each accepted transfer moves the address on by one half-word and counts toward the current length. When the count reaches the length, the block raises its interrupt. If software has refreshed the shadow length since the last swap, the shadow values replace the current ones and the channel keeps running. If it has not, the channel stops.

Software reaches the block through a byte-wide register port with eight offsets. Transfers arrive on a valid/ready pair. A transfer takes place on a rising clock edge where `xfer_valid` and `xfer_ready` are both high. `xfer_ready` is high exactly while the channel is active, which is how a stopped channel holds off its requester. The requester may keep `xfer_valid` high through back-pressure, and no transfer is counted while `xfer_ready` is low. `cur_addr` always gives the address of the next transfer.

Top module: `dma_block_sequencer`

## Requirements
- R1: After reset, all eight register offsets read 0. `cur_addr`, `active`, `xfer_ready` and `irq` are all 0.
- R2: The register map is as follows. Offset 0 holds length bits [7:0]. Offset 1 holds the enable in bit 7 and length bits [9:8] in bits 1:0; bits 6:2 read 0. Offsets 2 and 3 hold the current address low and high bytes. Offset 4 holds shadow length bits [7:0]. Offset 5 holds shadow length bits [9:8] in bits 1:0, and its other bits read 0. Offsets 6 and 7 hold the shadow address low and high bytes.
- R3: A write to offset 1 with bit 7 set enables the channel, makes `active` and `xfer_ready` 1 from the next cycle, and restarts the transfer count at zero. A write to offset 1 with bit 7 clear disables the channel and clears `active`.
- R4: `xfer_ready` equals `active`. Each accepted transfer that is not at a block end with a fresh shadow address raises `cur_addr` by 1 in the next cycle. The address wraps at 16 bits.
- R5: A current length of 0 is unlimited. No number of transfers sets `irq` or changes the length.
- R6: With a current length of N (1 to 1023), the Nth accepted transfer after the count restarts is a block end, and `irq` is 1 in the next cycle.
- R7: At a block end where the shadow length has been written since the last swap, the current length takes the shadow length and the channel stays active. The fresh mark is then cleared, so the following block end stops the channel unless the shadow length is written again.
- R8: At a block end where a shadow address byte has been written since the last swap, `cur_addr` takes the shadow address instead of incrementing, and that fresh mark is cleared. This happens whether the length swaps or not.
- R9: At a block end with no fresh shadow length, `active` and `xfer_ready` go to 0. `cur_addr` then holds while `xfer_valid` stays high.
- R10: Any write to offset 4 or 5 clears `irq`. If a block end happens in the same cycle, `irq` is set instead.
- R11: While the enable bit is 1, writes to offsets 4 and 5 leave the shadow length and its fresh mark unchanged. Shadow address writes are always accepted.
- R12: Offsets 0 and 1 read the current length, including a value just swapped in. Offsets 2 and 3 read the live current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write offset |
| reg_wr_data | input | 8 | Register write byte |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rd_data | output | 8 | Register read byte (combinational) |
| xfer_valid | input | 1 | Requester offers a transfer |
| xfer_ready | output | 1 | Channel accepts transfers (equals active) |
| cur_addr | output | 16 | Address of the next transfer |
| active | output | 1 | Channel is running |
| irq | output | 1 | Block-end interrupt |

## Verification
The assertions assume that software never writes a register in the same cycle as an accepted transfer. When that rule is broken, a register write takes priority and the step and freshness checks no longer describe the cycle. The stimulus keeps to the rule: it drops `xfer_valid` whenever it issues a write. Both the directed sequences and the random phase reprogram the channel only between transfer bursts. Block lengths cover 0, 1, small values, 3 and 1023, and the address is started near the 16-bit wrap point.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [2:0] {
    OFS_LEN_LO  = 3'd0,
    OFS_LEN_HI  = 3'd1,
    OFS_ADR_LO  = 3'd2,
    OFS_ADR_HI  = 3'd3,
    OFS_SHL_LO  = 3'd4,
    OFS_SHL_HI  = 3'd5,
    OFS_SHA_LO  = 3'd6,
    OFS_SHA_HI  = 3'd7
  } reg_ofs_e;

  localparam int ENABLE_BIT = 7;
endpackage

// File: rtl/dmaseq_blkcnt.sv
module dmaseq_blkcnt #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] limit,
  output logic             at_end
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign at_end  = (limit != '0) && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= at_end ? '0 : cnt_inc;
  end

  // R6: a counted block end leaves the count at zero
  a_r6_restart_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> (cnt_q == '0));
endmodule

// File: rtl/dmaseq_shadow.sv
module dmaseq_shadow import dmaseq_pkg::*; #(
  parameter int LEN_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_ofs_e          wr_ofs,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  input  logic              blk_end,
  output logic [LEN_W-1:0]  sh_len,
  output logic [ADDR_W-1:0] sh_addr,
  output logic              len_new,
  output logic              addr_new
);
  localparam int LEN_HI_W  = LEN_W - 8;
  localparam int ADDR_HI_W = ADDR_W - 8;

  logic shl_wr, sha_wr, shl_take;

  assign shl_wr   = wr_en && (wr_ofs == OFS_SHL_LO || wr_ofs == OFS_SHL_HI);
  assign sha_wr   = wr_en && (wr_ofs == OFS_SHA_LO || wr_ofs == OFS_SHA_HI);
  assign shl_take = shl_wr && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_len  <= '0;
      len_new <= 1'b0;
    end else if (shl_take) begin
      if (wr_ofs == OFS_SHL_LO) sh_len[7:0]       <= wr_data;
      else                      sh_len[LEN_W-1:8] <= wr_data[LEN_HI_W-1:0];
      len_new <= 1'b1;
    end else if (blk_end && len_new) begin
      len_new <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_addr  <= '0;
      addr_new <= 1'b0;
    end else if (sha_wr) begin
      if (wr_ofs == OFS_SHA_LO) sh_addr[7:0]        <= wr_data;
      else                      sh_addr[ADDR_W-1:8] <= wr_data[ADDR_HI_W-1:0];
      addr_new <= 1'b1;
    end else if (blk_end && addr_new) begin
      addr_new <= 1'b0;
    end
  end

  // R11: locked shadow-length writes leave value and fresh mark alone
  a_r11_locked_len: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_wr && lock) |=> ($stable(sh_len) && (len_new == $past(len_new) || !len_new)));

  // R7: a consumed fresh length is no longer fresh
  a_r7_fresh_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && len_new && !shl_take) |=> !len_new);
endmodule

// File: rtl/dma_block_sequencer.sv
module dma_block_sequencer import dmaseq_pkg::*; #(
  parameter int LEN_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic [2:0]        reg_rd_addr,
  output logic [7:0]        reg_rd_data,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              irq
);
  localparam int LEN_HI_W  = LEN_W - 8;
  localparam int ADDR_HI_W = ADDR_W - 8;

  reg_ofs_e          wofs, rofs;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  sh_len;
  logic [ADDR_W-1:0] sh_addr;
  logic              en_q, act_q, irq_q;
  logic              len_new, addr_new;
  logic              fire, at_end, blk_end;
  logic              wr_len_hi, wr_shl;

  assign wofs       = reg_ofs_e'(reg_wr_addr);
  assign rofs       = reg_ofs_e'(reg_rd_addr);
  assign fire       = xfer_valid && act_q;
  assign blk_end    = fire && at_end;
  assign wr_len_hi  = reg_wr_en && (wofs == OFS_LEN_HI);
  assign wr_shl     = reg_wr_en && (wofs == OFS_SHL_LO || wofs == OFS_SHL_HI);
  assign xfer_ready = act_q;
  assign active     = act_q;
  assign irq        = irq_q;

  dmaseq_blkcnt #(.LEN_W(LEN_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wr_len_hi),
    .step   (fire),
    .limit  (len_q),
    .at_end (at_end)
  );

  dmaseq_shadow #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_ofs   (wofs),
    .wr_data  (reg_wr_data),
    .lock     (en_q),
    .blk_end  (blk_end),
    .sh_len   (sh_len),
    .sh_addr  (sh_addr),
    .len_new  (len_new),
    .addr_new (addr_new)
  );

  // current length and enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      en_q  <= 1'b0;
    end else if (reg_wr_en && wofs == OFS_LEN_LO) begin
      len_q[7:0] <= reg_wr_data;
    end else if (wr_len_hi) begin
      len_q[LEN_W-1:8] <= reg_wr_data[LEN_HI_W-1:0];
      en_q             <= reg_wr_data[ENABLE_BIT];
    end else if (blk_end && len_new) begin
      len_q <= sh_len;
    end
  end

  // running state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   act_q <= 1'b0;
    else if (wr_len_hi)           act_q <= reg_wr_data[ENABLE_BIT];
    else if (blk_end && !len_new) act_q <= 1'b0;
  end

  // address counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cur_addr <= '0;
    else if (reg_wr_en && wofs == OFS_ADR_LO)  cur_addr[7:0] <= reg_wr_data;
    else if (reg_wr_en && wofs == OFS_ADR_HI)  cur_addr[ADDR_W-1:8] <= reg_wr_data[ADDR_HI_W-1:0];
    else if (blk_end && addr_new)              cur_addr <= sh_addr;
    else if (fire)                             cur_addr <= cur_addr + 1'b1;
  end

  // interrupt: set at a limited block end, cleared by a shadow-length write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (blk_end) irq_q <= 1'b1;
    else if (wr_shl)  irq_q <= 1'b0;
  end

  always_comb begin
    case (rofs)
      OFS_LEN_LO: reg_rd_data = len_q[7:0];
      OFS_LEN_HI: reg_rd_data = {en_q, {(7-LEN_HI_W){1'b0}}, len_q[LEN_W-1:8]};
      OFS_ADR_LO: reg_rd_data = cur_addr[7:0];
      OFS_ADR_HI: reg_rd_data = cur_addr[ADDR_W-1:8];
      OFS_SHL_LO: reg_rd_data = sh_len[7:0];
      OFS_SHL_HI: reg_rd_data = {{(8-LEN_HI_W){1'b0}}, sh_len[LEN_W-1:8]};
      OFS_SHA_LO: reg_rd_data = sh_addr[7:0];
      default:    reg_rd_data = sh_addr[ADDR_W-1:8];
    endcase
  end

  // R6: the interrupt only rises after an accepted transfer
  a_r6_irq_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(xfer_valid && xfer_ready));

  // R9: the channel only stops through a write or a transfer
  a_r9_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(reg_wr_en) || $past(xfer_valid)));

  // R4: a plain transfer moves the address on by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !reg_wr_en && !at_end) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R5: an unlimited block never raises the interrupt
  a_r5_unlimited_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0 && !irq) |=> !irq);
endmodule

// File: tb/tb_dma_block_sequencer.sv
module tb_dma_block_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [7:0]  reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [7:0]  reg_rd_data;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [15:0] cur_addr;
  logic        active;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_block_sequencer dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .cur_addr(cur_addr), .active(active), .irq(irq)
  );

  // behavioural reference state
  int m_len, m_en, m_act, m_addr, m_cnt, m_sl, m_sa, m_lnew, m_anew, m_irq;

  function automatic int model_read(input int ofs);
    case (ofs)
      0: return m_len % 256;
      1: return m_en * 128 + m_len / 256;
      2: return m_addr % 256;
      3: return m_addr / 256;
      4: return m_sl % 256;
      5: return m_sl / 256;
      6: return m_sa % 256;
      default: return m_sa / 256;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_en = 0; m_act = 0; m_addr = 0; m_cnt = 0;
      m_sl = 0; m_sa = 0; m_lnew = 0; m_anew = 0; m_irq = 0;
    end else begin
      int ofs, d, fire, endb, lock;
      ofs  = reg_wr_en ? int'(reg_wr_addr) : -1;
      d    = int'(reg_wr_data);
      fire = (xfer_valid && m_act != 0) ? 1 : 0;
      endb = (fire != 0 && m_len != 0 && m_cnt + 1 == m_len) ? 1 : 0;
      lock = m_en;
      if (ofs == 1) m_cnt = 0;
      else if (fire != 0) m_cnt = (endb != 0) ? 0 : (m_cnt + 1) % 1024;
      if (ofs == 1) m_act = d / 128;
      else if (endb != 0 && m_lnew == 0) m_act = 0;
      if (ofs == 0) m_len = (m_len / 256) * 256 + d;
      else if (ofs == 1) begin m_len = (d % 4) * 256 + m_len % 256; m_en = d / 128; end
      else if (endb != 0 && m_lnew != 0) m_len = m_sl;
      if (ofs == 2) m_addr = (m_addr / 256) * 256 + d;
      else if (ofs == 3) m_addr = d * 256 + m_addr % 256;
      else if (endb != 0 && m_anew != 0) m_addr = m_sa;
      else if (fire != 0) m_addr = (m_addr + 1) % 65536;
      if (endb != 0) m_irq = 1;
      else if (ofs == 4 || ofs == 5) m_irq = 0;
      if ((ofs == 4 || ofs == 5) && lock == 0) begin
        if (ofs == 4) m_sl = (m_sl / 256) * 256 + d;
        else m_sl = (d % 4) * 256 + m_sl % 256;
        m_lnew = 1;
      end else if (endb != 0) m_lnew = 0;
      if (ofs == 6 || ofs == 7) begin
        if (ofs == 6) m_sa = (m_sa / 256) * 256 + d;
        else m_sa = d * 256 + m_sa % 256;
        m_anew = 1;
      end else if (endb != 0) m_anew = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R4", "cur_addr", int'(cur_addr), m_addr);
      chk("R3", "active", int'(active), m_act);
      chk("R4", "xfer_ready", int'(xfer_ready), m_act);
      chk("R6", "irq", int'(irq), m_irq);
      chk("R12", "reg_rd_data", int'(reg_rd_data), model_read(int'(reg_rd_addr)));
    end
  end

  task automatic wr(input int ofs, input int data);
    @(negedge clk);
    xfer_valid = 1'b0;
    reg_wr_en = 1'b1; reg_wr_addr = 3'(ofs); reg_wr_data = 8'(data);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    xfer_valid = 1'b1;
    repeat (n) @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int ofs, input int exp);
    @(negedge clk);
    reg_rd_addr = 3'(ofs);
    #1;
    chk(req, $sformatf("read offset %0d", ofs), int'(reg_rd_data), exp);
  endtask

  task automatic port_chk(input string req, input string what, input int act, input int exp);
    #1;
    chk(req, what, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    port_chk("R1", "cur_addr", int'(cur_addr), 0);
    port_chk("R1", "active", int'(active), 0);
    port_chk("R1", "xfer_ready", int'(xfer_ready), 0);
    port_chk("R1", "irq", int'(irq), 0);
    for (int i = 0; i < 8; i++) rd_chk("R1", i, 0);

    // limited block with both shadows fresh
    wr(2, 8'h10); wr(3, 8'h00); wr(0, 3);
    wr(6, 8'h00); wr(7, 8'h01); wr(4, 2);
    wr(1, 8'h80);
    port_chk("R3", "active after enable", int'(active), 1);
    rd_chk("R2", 1, 8'h80);
    xfer(2);
    port_chk("R4", "addr after two", int'(cur_addr), 16'h0012);
    port_chk("R6", "irq before end", int'(irq), 0);
    xfer(1);
    port_chk("R6", "irq at end", int'(irq), 1);
    port_chk("R7", "active after swap", int'(active), 1);
    port_chk("R8", "addr after swap", int'(cur_addr), 16'h0100);
    rd_chk("R12", 0, 2);
    xfer(1);
    port_chk("R4", "addr step", int'(cur_addr), 16'h0101);
    wr(4, 9);
    port_chk("R10", "irq cleared", int'(irq), 0);
    rd_chk("R11", 4, 2);
    xfer(1);
    port_chk("R9", "active after stale end", int'(active), 0);
    port_chk("R9", "xfer_ready after stop", int'(xfer_ready), 0);
    port_chk("R6", "irq second end", int'(irq), 1);
    port_chk("R8", "addr without fresh shadow", int'(cur_addr), 16'h0102);
    xfer(3);
    port_chk("R9", "addr held while stopped", int'(cur_addr), 16'h0102);

    // unlimited block across the address wrap
    wr(1, 0); wr(4, 5); wr(0, 0);
    wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h80);
    xfer(1100);
    port_chk("R5", "irq unlimited", int'(irq), 0);
    port_chk("R5", "active unlimited", int'(active), 1);
    port_chk("R4", "addr wrapped", int'(cur_addr), 16'h043C);

    // largest block length
    wr(1, 0); wr(0, 8'hFF); wr(1, 8'h83);
    xfer(1022);
    port_chk("R6", "irq before 1023", int'(irq), 0);
    xfer(1);
    port_chk("R6", "irq at 1023", int'(irq), 1);
    port_chk("R7", "active after swap", int'(active), 1);
    rd_chk("R7", 0, 5);
    rd_chk("R2", 1, 8'h80);
    port_chk("R4", "addr after 1023", int'(cur_addr), 16'h083B);
    wr(1, 8'h7F);
    rd_chk("R2", 1, 8'h03);
    rd_chk("R2", 5, 0);

    // random phase, reference compared every cycle
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) begin
        wr(1, 0);
        wr(4, $urandom_range(0, 12)); wr(5, $urandom_range(0, 1) * 4);
        if ($urandom_range(0, 1) == 1) begin wr(6, $urandom_range(0, 255)); wr(7, $urandom_range(0, 255)); end
        wr(0, $urandom_range(0, 9));
        wr(1, 8'h80);
      end else if (r < 10) begin
        wr($urandom_range(4, 7), $urandom_range(0, 255));
      end else begin
        @(negedge clk);
        reg_rd_addr = 3'($urandom_range(0, 7));
        xfer_valid = ($urandom_range(0, 3) != 0);
      end
    end
    @(negedge clk);
    xfer_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule